// File: doc/BRIEF.md
# Vectored interrupt controller

This block gathers level-sensitive request lines from a set of peripheral channels and presents two outputs to a processor core. The first is a fast interrupt line, which is the OR of every enabled channel that software has placed in the fast class. The second is a normal interrupt line for every other enabled channel. Fast-class requests bypass arbitration entirely. A status word tells a shared fast handler which sources are asking.

Normal-class channels each carry a 4-bit priority level, where 0 is the most urgent, and a handler address. A registered arbiter picks the most urgent pending channel every clock, and on a tie the lowest channel index wins. Reading the vector register returns the winner's handler address. When no normal request is eligible, the read returns a programmable default address instead. A vector read that finds a winner places that winner's level in service. Requests at that level or any less urgent level are then held off until software writes the acknowledge register, while more urgent levels can still nest on top. The channel count must be a power of two and no larger than the data width.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `fiq_o` is high exactly when some channel has its request high, its enable bit set and its fast-select bit set. It follows the request lines combinationally and is not affected by any in-service level.
- R2: A read of the fast status word (address 0x02) returns, for each channel n in bit n, the AND of its request, its enable bit and its fast-select bit.
- R3: A channel whose enable bit is 0 has no effect on `fiq_o`, on the fast status word, on `irq_o` or on the vector address, whatever its request, class or priority.
- R4: `irq_o` is high on the clock after any cycle in which at least one enabled, normal-class, unmasked channel is requesting, and low otherwise.
- R5: A vector read (address 0x03) returns the handler address of the eligible channel with the numerically smallest priority, as registered on the previous clock. Among equal priorities, the lowest channel index wins.
- R6: A fast-class channel never takes part in normal arbitration, even when its priority field is the most urgent.
- R7: A vector read when no winner is registered returns the default address (address 0x05) and places no level in service.
- R8: A vector read with a winner places that priority level in service. From then on, requests whose priority is numerically greater than or equal to the most urgent in-service level are removed from `irq_o` and from arbitration. Strictly more urgent requests still win, and a vector read of one of them stacks its level as well.
- R9: Any write to the acknowledge register (address 0x04) takes only the most urgent in-service level out of service.
- R10: After reset, every control register, priority field, handler address, the default address and the in-service state are zero, and `fiq_o`, `irq_o` and `bus_rdata_o` are low.
- R11: The register map is: 0x00 enable bits, 0x01 fast-select bits, 0x05 default address, 0x20+n the priority of channel n (low 4 bits, read back zero-extended), 0x40+n the handler address of channel n. Read data is registered: it appears on the clock after a read (`bus_sel_i` high, `bus_we_i` low) and holds until the next read. Unmapped addresses and the acknowledge register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | N_CH | Level request line per channel |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | CH_W+2 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| fiq_o | output | 1 | Fast interrupt to the core |
| irq_o | output | 1 | Normal interrupt to the core |

## Verification
The vector read and the arbitration update happen on the same edge. The read must return the winner that was registered the clock before. The level it marks in service then takes effect only in the next arbitration, so `irq_o` drops one clock later. The bench provokes this by reading the vector while equal-level and more urgent requests rise and fall around the read, and it nests a second read on top of a held level. A behavioural model steps the same edge ordering and compares `irq_o`, `fiq_o` and read data on every clock. This catches any off-by-one in masking or in which winner a read sees.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // upper two address bits pick the region
  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_PRIO = 2'd1,
    RG_VECT = 2'd2,
    RG_NONE = 2'd3
  } ivc_region_e;

  // control registers inside RG_CTRL
  typedef enum logic [2:0] {
    CR_ENABLE  = 3'd0,
    CR_FASTSEL = 3'd1,
    CR_FSTAT   = 3'd2,
    CR_VECTOR  = 3'd3,
    CR_ACK     = 3'd4,
    CR_DEFVEC  = 3'd5
  } ivc_ctl_e;
endpackage

// File: rtl/ivc_rst_sync.sv
module ivc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [N_CH-1:0]              req_i,
  input  logic                         win_vld_i,
  input  logic [CH_W-1:0]              win_idx_i,
  output logic [N_CH-1:0]              en_o,
  output logic [N_CH-1:0]              fast_o,
  output logic [N_CH-1:0][PRIO_W-1:0]  prio_o,
  output logic                         mark_o,
  output logic                         ack_o
);
  ivc_region_e region;
  ivc_ctl_e    ctl;
  logic        ctl_hit;
  logic [CH_W-1:0] ent;

  logic wr_en, wr_fast, wr_def, rd_vec;
  logic [N_CH-1:0] wr_prio, wr_vect;

  logic [N_CH-1:0] en_q, fast_q;
  logic [DATA_W-1:0] def_q;
  logic [N_CH-1:0][PRIO_W-1:0] prio_q;
  logic [N_CH-1:0][DATA_W-1:0] vect_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic rd_stb;

  assign region  = ivc_region_e'(addr_i[ADDR_W-1 -: 2]);
  assign ctl     = ivc_ctl_e'(addr_i[2:0]);
  assign ent     = addr_i[CH_W-1:0];
  assign ctl_hit = (region == RG_CTRL) && (addr_i[CH_W-1:3] == '0);

  // decode
  assign wr_en   = sel_i && we_i && ctl_hit && (ctl == CR_ENABLE);
  assign wr_fast = sel_i && we_i && ctl_hit && (ctl == CR_FASTSEL);
  assign wr_def  = sel_i && we_i && ctl_hit && (ctl == CR_DEFVEC);
  assign ack_o   = sel_i && we_i && ctl_hit && (ctl == CR_ACK);
  assign rd_stb  = sel_i && !we_i;
  assign rd_vec  = rd_stb && ctl_hit && (ctl == CR_VECTOR);
  assign mark_o  = rd_vec && win_vld_i;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_dec
      assign wr_prio[c] = sel_i && we_i && (region == RG_PRIO) && (ent == CH_W'(c));
      assign wr_vect[c] = sel_i && we_i && (region == RG_VECT) && (ent == CH_W'(c));
    end
  endgenerate

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      fast_q <= '0;
      def_q  <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata_i[N_CH-1:0];
      if (wr_fast) fast_q <= wdata_i[N_CH-1:0];
      if (wr_def)  def_q  <= wdata_i;
    end
  end

  // per-channel tables
  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_tab
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prio_q[c] <= '0;
          vect_q[c] <= '0;
        end else begin
          if (wr_prio[c]) prio_q[c] <= wdata_i[PRIO_W-1:0];
          if (wr_vect[c]) vect_q[c] <= wdata_i;
        end
      end
    end
  endgenerate

  // read mux
  always_comb begin
    rdata_d = '0;
    unique case (region)
      RG_CTRL: begin
        if (ctl_hit) begin
          case (ctl)
            CR_ENABLE:  rdata_d = DATA_W'(en_q);
            CR_FASTSEL: rdata_d = DATA_W'(fast_q);
            CR_FSTAT:   rdata_d = DATA_W'(req_i & en_q & fast_q);
            CR_VECTOR:  rdata_d = win_vld_i ? vect_q[win_idx_i] : def_q;
            CR_DEFVEC:  rdata_d = def_q;
            default:    rdata_d = '0;
          endcase
        end
      end
      RG_PRIO: rdata_d = DATA_W'(prio_q[ent]);
      RG_VECT: rdata_d = vect_q[ent];
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign fast_o  = fast_q;
  assign prio_o  = prio_q;

  // R7: a vector read with no winner returns the default address
  assert_vec_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !win_vld_i) |=> (rdata_o == $past(def_q)));
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int N_CH   = 32,
  parameter int PRIO_W = 4,
  localparam int CH_W  = $clog2(N_CH),
  localparam int NODES = 2 * N_CH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CH-1:0]             req_i,
  input  logic [N_CH-1:0]             en_i,
  input  logic [N_CH-1:0]             fast_i,
  input  logic [N_CH-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W:0]             thr_i,
  output logic                        win_vld_o,
  output logic [CH_W-1:0]             win_idx_o,
  output logic [PRIO_W-1:0]           win_prio_o
);
  logic [N_CH-1:0] elig;

  // heap-ordered tournament: node k has children 2k and 2k+1, leaves at N_CH+c
  logic              nv [1:NODES-1];
  logic [PRIO_W-1:0] np [1:NODES-1];
  logic [CH_W-1:0]   ni [1:NODES-1];

  logic              win_vld_q;
  logic [CH_W-1:0]   win_idx_q;
  logic [PRIO_W-1:0] win_prio_q;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_leaf
      assign elig[c]      = req_i[c] && en_i[c] && !fast_i[c] &&
                            ({1'b0, prio_i[c]} < thr_i);
      assign nv[N_CH + c] = elig[c];
      assign np[N_CH + c] = prio_i[c];
      assign ni[N_CH + c] = CH_W'(c);
    end
    for (genvar k = 1; k < N_CH; k++) begin : g_node
      logic take_lo;
      // left child holds lower channel indices, so it keeps ties
      assign take_lo = nv[2*k] && (!nv[2*k+1] || (np[2*k] <= np[2*k+1]));
      assign nv[k] = nv[2*k] || nv[2*k+1];
      assign np[k] = take_lo ? np[2*k] : np[2*k+1];
      assign ni[k] = take_lo ? ni[2*k] : ni[2*k+1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_vld_q  <= 1'b0;
      win_idx_q  <= '0;
      win_prio_q <= '0;
    end else begin
      win_vld_q  <= nv[1];
      win_idx_q  <= ni[1];
      win_prio_q <= np[1];
    end
  end

  assign win_vld_o  = win_vld_q;
  assign win_idx_o  = win_idx_q;
  assign win_prio_o = win_prio_q;

  // R4: registered winner valid tracks any eligible request one clock earlier
  assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_q == $past(|elig));

  // R5: the registered winner was eligible on the previous clock
  assert_winner_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_q |-> (($past(elig) & (N_CH'(1) << win_idx_q)) != '0));
endmodule

// File: rtl/ivc_inservice.sv
module ivc_inservice #(
  parameter int PRIO_W = 4,
  localparam int LEVELS = 1 << PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_i,
  input  logic [PRIO_W-1:0] mark_lvl_i,
  input  logic              ack_i,
  output logic [PRIO_W:0]   thr_o
);
  logic [LEVELS-1:0] isv_q, isv_d;
  logic [PRIO_W:0]   thr;

  always_comb begin
    isv_d = isv_q;
    if (ack_i)  isv_d = isv_d & (isv_d - LEVELS'(1));
    if (mark_i) isv_d[mark_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               isv_q <= '0;
    else if (ack_i || mark_i) isv_q <= isv_d;
  end

  // most urgent level in service, or LEVELS when none
  always_comb begin
    thr = (PRIO_W+1)'(LEVELS);
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (isv_q[l]) thr = (PRIO_W+1)'(l);
    end
  end

  assign thr_o = thr;

  // R9: an acknowledge alone retires exactly one level
  assert_ack_pops_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !mark_i && (isv_q != '0)) |=>
      ($countones(isv_q) == $countones($past(isv_q)) - 1));

  // R8: a marked level is in service on the next clock
  assert_mark_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |=> isv_q[$past(mark_lvl_i)]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   irq_req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  logic                        rst_s_n;
  logic [N_CH-1:0]             en, fast;
  logic [N_CH-1:0][PRIO_W-1:0] prio;
  logic                        win_vld;
  logic [CH_W-1:0]             win_idx;
  logic [PRIO_W-1:0]           win_prio;
  logic [PRIO_W:0]             thr;
  logic                        mark, ack;

  ivc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  ivc_regs #(.N_CH(N_CH), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sel_i     (bus_sel_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .req_i     (irq_req_i),
    .win_vld_i (win_vld),
    .win_idx_i (win_idx),
    .en_o      (en),
    .fast_o    (fast),
    .prio_o    (prio),
    .mark_o    (mark),
    .ack_o     (ack)
  );

  ivc_arbiter #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .req_i      (irq_req_i),
    .en_i       (en),
    .fast_i     (fast),
    .prio_i     (prio),
    .thr_i      (thr),
    .win_vld_o  (win_vld),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  ivc_inservice #(.PRIO_W(PRIO_W)) u_isv (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .mark_i     (mark),
    .mark_lvl_i (win_prio),
    .ack_i      (ack),
    .thr_o      (thr)
  );

  assign fiq_o = |(irq_req_i & en & fast);
  assign irq_o = win_vld;

  // R6: a fast-class channel is never the normal winner
  assert_fast_excluded_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    win_vld |-> !$past(fast[win_idx]));

  // R8: the winner is strictly more urgent than the in-service threshold
  assert_below_threshold_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    win_vld |-> ({1'b0, win_prio} < $past(thr)));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int N  = 32;
  localparam int PW = 4;
  localparam int DW = 32;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          fiq, irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.N_CH(N), .PRIO_W(PW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [N-1:0] m_en, m_fs;
  int         m_prio [N];
  bit [31:0]  m_vect [N];
  bit [31:0]  m_def, m_rd;
  int         held [$];     // levels in service
  bit         m_wv;
  int         m_wi, m_wp;

  function automatic int m_thr();
    int t = 16;
    foreach (held[i]) if (held[i] < t) t = held[i];
    return t;
  endfunction

  task automatic m_reset();
    m_en = '0; m_fs = '0; m_def = '0; m_rd = '0;
    for (int c = 0; c < N; c++) begin m_prio[c] = 0; m_vect[c] = '0; end
    held.delete();
    m_wv = 0; m_wi = 0; m_wp = 0;
  endtask

  task automatic m_step();
    int t, bp, bi;
    bit bv;
    t = m_thr(); bv = 0; bp = 99; bi = 0;
    for (int c = 0; c < N; c++)
      if (req[c] && m_en[c] && !m_fs[c] && m_prio[c] < t && m_prio[c] < bp) begin
        bv = 1; bp = m_prio[c]; bi = c;
      end
    if (sel && we) begin
      int a = int'(addr);
      if (a == 0) m_en = wdata;
      else if (a == 1) m_fs = wdata;
      else if (a == 5) m_def = wdata;
      else if (a == 4 && held.size() > 0) begin
        int mn = m_thr();
        foreach (held[i]) if (held[i] == mn) begin held.delete(i); break; end
      end
      else if (a >= 32 && a < 64) m_prio[a-32] = int'(wdata[3:0]);
      else if (a >= 64 && a < 96) m_vect[a-64] = wdata;
    end else if (sel) begin
      int a = int'(addr);
      if (a == 0) m_rd = m_en;
      else if (a == 1) m_rd = m_fs;
      else if (a == 2) m_rd = req & m_en & m_fs;
      else if (a == 3) begin
        m_rd = m_wv ? m_vect[m_wi] : m_def;
        if (m_wv) begin
          bit there = 0;
          foreach (held[i]) if (held[i] == m_wp) there = 1;
          if (!there) held.push_back(m_wp);
        end
      end
      else if (a == 5) m_rd = m_def;
      else if (a >= 32 && a < 64) m_rd = 32'(m_prio[a-32]);
      else if (a >= 64 && a < 96) m_rd = m_vect[a-64];
      else m_rd = '0;
    end
    m_wv = bv; m_wi = bi; m_wp = bp;
  endtask

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // model step on each edge, compare just after it
  always begin
    @(posedge clk);
    if (!rst_n) m_reset();
    else m_step();
    #1;
    if (rst_n && !done) begin
      check("R1 fiq", 32'(fiq), 32'(|(req & m_en & m_fs)));
      check("R4 irq", 32'(irq), 32'(m_wv));
      check("R11 rdata", rdata, m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = AW'(a);
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic set_req(input logic [N-1:0] r);
    @(negedge clk); req = r;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] hv(int c);
    return 32'h8000_0000 | (32'(c) << 4);
  endfunction

  localparam logic [31:0] DEFV = 32'h0000_F00D;

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 fiq", 32'(fiq), 0);
    check("R10 irq", 32'(irq), 0);
    check("R10 rdata", rdata, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rd(0, v);  check("R10 enable", v, 0);
    rd(32 + 7, v); check("R10 prio", v, 0);
    rd(64 + 7, v); check("R10 vect", v, 0);

    // programming
    for (int c = 0; c < N; c++) begin
      int p = 7;
      if (c == 5 || c == 10) p = 2;
      if (c == 20) p = 1;
      if (c == 12 || c == 3) p = 0;
      wr(32 + c, 32'(p) | 32'hFFFF_FFF0);
      wr(64 + c, hv(c));
    end
    wr(5, DEFV);
    wr(0, ~((32'd1 << 9) | (32'd1 << 12)));
    wr(1, (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 9));

    // R11: read back
    rd(32 + 5, v);  check("R11 prio zero-extended", v, 2);
    rd(64 + 20, v); check("R11 vect", v, hv(20));
    rd(5, v);       check("R11 default", v, DEFV);
    rd(0, v);       check("R11 enable", v, ~((32'd1 << 9) | (32'd1 << 12)));
    rd(4, v);       check("R11 ack reads zero", v, 0);

    // R1 R2 R3: fast class
    set_req((32'd1 << 3) | (32'd1 << 9));
    check("R1 fiq on fast", 32'(fiq), 1);
    check("R6 irq off for fast", 32'(irq), 0);
    rd(2, v); check("R2 R3 fast status", v, 32'd1 << 3);
    set_req(32'd1 << 9);
    check("R3 disabled fast no fiq", 32'(fiq), 0);

    // R5: priority then tie
    set_req((32'd1 << 5) | (32'd1 << 10) | (32'd1 << 20));
    rd(3, v); check("R5 most urgent", v, hv(20));
    wr(4, 0);
    set_req((32'd1 << 5) | (32'd1 << 10));
    rd(3, v); check("R5 tie lowest index", v, hv(5));
    wr(4, 0);

    // R6: fast channel with priority 0 excluded
    set_req((32'd1 << 3) | (32'd1 << 10));
    rd(3, v); check("R6 fast excluded", v, hv(10));
    wr(4, 0);

    // R3: disabled channel with priority 0
    set_req((32'd1 << 12) | (32'd1 << 10));
    rd(3, v); check("R3 disabled ignored", v, hv(10));
    wr(4, 0);
    set_req(32'd1 << 12);
    check("R3 disabled no irq", 32'(irq), 0);

    // R7: default, nothing marked
    set_req('0);
    rd(3, v); check("R7 default vector", v, DEFV);
    set_req(32'd1 << 10);
    check("R7 no level marked", 32'(irq), 1);

    // R8 R9: masking, nesting, acknowledge
    set_req((32'd1 << 5) | (32'd1 << 10));
    rd(3, v); check("R8 first read", v, hv(5));
    repeat (3) @(negedge clk);
    check("R8 equal level masked", 32'(irq), 0);
    rd(3, v); check("R8 masked read gives default", v, DEFV);
    set_req((32'd1 << 5) | (32'd1 << 10) | (32'd1 << 20));
    check("R8 more urgent passes", 32'(irq), 1);
    rd(3, v); check("R8 nested read", v, hv(20));
    set_req((32'd1 << 5) | (32'd1 << 10));
    check("R8 irq low while nested", 32'(irq), 0);
    wr(4, 0);
    repeat (2) @(negedge clk);
    check("R9 one level retired only", 32'(irq), 0);
    wr(4, 0);
    repeat (2) @(negedge clk);
    check("R9 second ack frees level", 32'(irq), 1);
    rd(3, v); check("R9 vector after release", v, hv(5));
    wr(4, 0);
    set_req('0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule